// File: doc/BRIEF.md
# CAN Bus-Off Recovery Controller

This block holds the transmit and receive error counters of a CAN node and manages what happens around the bus-off condition. It also owns the reset-mode bit: software may set or clear it, and the block forces it on when the node goes bus-off. The transmit counter can be preset by software, but only while reset mode is on. That value is not acted on until software leaves reset mode. At that point a saturated value sends the node into bus-off exactly as an error-driven overflow would.

After a bus-off, the node stays isolated until software clears reset mode. The node must then observe 128 bus-free indications. These come from the bit-level logic, one pulse per detected idle sequence. The transmit counter shows the progress of recovery. If software sets reset mode again part way through, the counter freezes and the node stays bus-off until reset mode is cleared once more. The block reports the counters, a bus-status bit, an error-status bit, a one-cycle bus-off event pulse and a status-change pulse for the interrupt logic.

Top module: `can_busoff_ctrl`

## Requirements
- R1: After reset, reset_mode_o is 1; tec_o, rec_o, bus_off_o, err_warn_o, bus_off_evt_o and stat_chg_o are all 0.
- R2: When reset mode is clear and the node is not bus-off, a tx_err_i cycle adds tx_err_amt_i to the transmit counter. In reset mode, tx_err_i has no effect.
- R3: If that addition would take the transmit counter above 255, the next cycle shows all of the following: bus_off_o=1, reset_mode_o=1, tec_o=127, rec_o=0, and bus_off_evt_o=1 for exactly one cycle.
- R4: A tec_wr_i write loads tec_wdata_i into the transmit counter only while reset mode is set. While reset mode stays set, the written value causes no bus-off. Outside reset mode, a write is ignored.
- R5: When reset mode is cleared and the last value written is 255, the node enters bus-off with the same outcome as R3.
- R6: When reset mode is cleared and the last value written is below 255, the node does not enter bus-off and tec_o keeps the written value.
- R7: While bus-off with reset mode clear, each bus_free_i pulse lowers tec_o by one, from 127 down to 0. The 128th pulse clears bus_off_o, leaves tec_o at 0 and clears rec_o.
- R8: While reset mode is set, bus_free_i has no effect. If reset mode is set again during recovery, tec_o holds its value and bus_off_o stays 1. Recovery resumes from that value once reset mode is cleared.
- R9: err_warn_o is 1 exactly when tec_o >= 96 or rec_o >= 96.
- R10: stat_chg_o is 1 for one cycle in each cycle where bus_off_o or err_warn_o differs from its value in the previous cycle.
- R11: When reset mode is clear and the node is not bus-off, an rx_err_i cycle adds rx_err_amt_i to the receive counter, saturating at 255. Otherwise rx_err_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_wr_i | input | 1 | Software write strobe for the reset-mode bit |
| mode_val_i | input | 1 | Reset-mode value to write |
| tec_wr_i | input | 1 | Software write strobe for the transmit counter |
| tec_wdata_i | input | 8 | Transmit counter write value |
| tx_err_i | input | 1 | Transmit error event from the error logic |
| tx_err_amt_i | input | 8 | Amount to add to the transmit counter |
| rx_err_i | input | 1 | Receive error event from the error logic |
| rx_err_amt_i | input | 8 | Amount to add to the receive counter |
| bus_free_i | input | 1 | One pulse per detected bus-idle sequence |
| tec_o | output | 8 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| reset_mode_o | output | 1 | Reset-mode bit |
| bus_off_o | output | 1 | Bus status: node is bus-off |
| err_warn_o | output | 1 | Error status: a counter is at the warning level |
| bus_off_evt_o | output | 1 | One-cycle pulse on each bus-off entry |
| stat_chg_o | output | 1 | One-cycle pulse when bus or error status changes |

## Verification
The hardest situation to reach is a recovery that is interrupted by reset mode part way through. The stimulus first forces bus-off through a written value of 255, then clears reset mode and walks the counter down pulse by pulse. It re-asserts reset mode at a count of 77, sends bus-free pulses that must be ignored, and then resumes until the exact 128th pulse. A sweep of every write value from 0 to 255 checks at each step that the written value is evaluated only when reset mode is left, and checks the error status for that value.

// File: rtl/can_bo_pkg.sv
package can_bo_pkg;
  localparam int unsigned CNT_W_DEF = 8;
  localparam int unsigned WARN_DEF = 96;
  localparam int unsigned RECOV_DEF = 128;
endpackage

// File: rtl/bo_tec_ctrl.sv
module bo_tec_ctrl #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned RECOV_LEN = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_wr_i,
  input  logic             mode_val_i,
  input  logic             tec_wr_i,
  input  logic [CNT_W-1:0] tec_wdata_i,
  input  logic             tx_err_i,
  input  logic [CNT_W-1:0] amt_i,
  input  logic             bus_free_i,
  output logic [CNT_W-1:0] tec_o,
  output logic             init_o,
  output logic             bus_off_o,
  output logic             evt_o,
  output logic             active_o,
  output logic             clr_rec_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(RECOV_LEN - 1);

  logic [CNT_W-1:0] tec_q, wval;
  logic [CNT_W:0]   sum;
  logic init_q, bo_q, pend_q, evt_q;
  logic leave, wr_ok, active, ovf, wr_bo, enter_bo, recov_done;

  always_comb begin
    leave      = mode_wr_i && !mode_val_i && init_q;
    wr_ok      = tec_wr_i && init_q;
    wval       = wr_ok ? tec_wdata_i : tec_q;
    sum        = {1'b0, tec_q} + {1'b0, amt_i};
    active     = !init_q && !bo_q;
    ovf        = active && tx_err_i && sum[CNT_W];
    // written value is only judged when reset mode is left
    wr_bo      = leave && (pend_q || wr_ok) && (wval == CNT_MAX);
    enter_bo   = ovf || wr_bo;
    recov_done = bo_q && !init_q && bus_free_i && (tec_q == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tec_q  <= '0;
      init_q <= 1'b1;
      bo_q   <= 1'b0;
      pend_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      evt_q <= enter_bo;
      if (enter_bo) begin
        tec_q  <= LOAD;
        bo_q   <= 1'b1;
        init_q <= 1'b1;
        pend_q <= 1'b0;
      end else begin
        if (recov_done) begin
          tec_q <= '0;
          bo_q  <= 1'b0;
        end else if (wr_ok) begin
          tec_q <= tec_wdata_i;
        end else if (bo_q && !init_q && bus_free_i) begin
          tec_q <= tec_q - 1'b1;
        end else if (active && tx_err_i) begin
          tec_q <= sum[CNT_W-1:0];
        end
        if (leave)      pend_q <= 1'b0;
        else if (wr_ok) pend_q <= 1'b1;
        if (mode_wr_i)  init_q <= mode_val_i;
      end
    end
  end

  assign tec_o     = tec_q;
  assign init_o    = init_q;
  assign bus_off_o = bo_q;
  assign evt_o     = evt_q;
  assign active_o  = active;
  assign clr_rec_o = enter_bo || recov_done;

  p_bo_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bo_q) |-> (tec_q == LOAD) && init_q);
  p_evt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> bo_q && init_q && (tec_q == LOAD));
  p_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bo_q && init_q && !tec_wr_i && !mode_wr_i) |=> $stable(tec_q) && bo_q);
  p_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bo_q && !init_q && bus_free_i && (tec_q != '0))
      |=> bo_q && (tec_q == CNT_W'($past(tec_q) - 1'b1)));
endmodule

// File: rtl/bo_rec_ctrl.sv
module bo_rec_ctrl #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] amt_i,
  output logic [CNT_W-1:0] rec_o
);
  logic [CNT_W-1:0] rec_q;
  logic [CNT_W:0]   sum;

  assign sum = {1'b0, rec_q} + {1'b0, amt_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rec_q <= '0;
    else if (clr_i) rec_q <= '0;
    else if (inc_i) rec_q <= sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  end

  assign rec_o = rec_q;

  p_no_wrap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> rec_q >= $past(rec_q));
endmodule

// File: rtl/bo_status.sv
module bo_status #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned WARN_LIM = 96
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] tec_i,
  input  logic [CNT_W-1:0] rec_i,
  input  logic             bus_off_i,
  output logic             err_o,
  output logic             chg_o
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(WARN_LIM);
  logic err_prev_q, bo_prev_q;

  assign err_o = (tec_i >= LIM) || (rec_i >= LIM);
  assign chg_o = (err_o != err_prev_q) || (bus_off_i != bo_prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_prev_q <= 1'b0;
      bo_prev_q  <= 1'b0;
    end else begin
      err_prev_q <= err_o;
      bo_prev_q  <= bus_off_i;
    end
  end

  p_chg_bo_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(bus_off_i) |-> chg_o);
endmodule

// File: rtl/can_busoff_ctrl.sv
module can_busoff_ctrl
  import can_bo_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned WARN_LIM = WARN_DEF,
  parameter int unsigned RECOV_LEN = RECOV_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_wr_i,
  input  logic             mode_val_i,
  input  logic             tec_wr_i,
  input  logic [CNT_W-1:0] tec_wdata_i,
  input  logic             tx_err_i,
  input  logic [CNT_W-1:0] tx_err_amt_i,
  input  logic             rx_err_i,
  input  logic [CNT_W-1:0] rx_err_amt_i,
  input  logic             bus_free_i,
  output logic [CNT_W-1:0] tec_o,
  output logic [CNT_W-1:0] rec_o,
  output logic             reset_mode_o,
  output logic             bus_off_o,
  output logic             err_warn_o,
  output logic             bus_off_evt_o,
  output logic             stat_chg_o
);
  logic active, clr_rec;

  bo_tec_ctrl #(.CNT_W(CNT_W), .RECOV_LEN(RECOV_LEN)) u_tec (
    .clk_i, .rst_ni, .mode_wr_i, .mode_val_i, .tec_wr_i, .tec_wdata_i,
    .tx_err_i, .amt_i(tx_err_amt_i), .bus_free_i,
    .tec_o, .init_o(reset_mode_o), .bus_off_o, .evt_o(bus_off_evt_o),
    .active_o(active), .clr_rec_o(clr_rec)
  );

  bo_rec_ctrl #(.CNT_W(CNT_W)) u_rec (
    .clk_i, .rst_ni, .clr_i(clr_rec), .inc_i(rx_err_i && active),
    .amt_i(rx_err_amt_i), .rec_o
  );

  bo_status #(.CNT_W(CNT_W), .WARN_LIM(WARN_LIM)) u_stat (
    .clk_i, .rst_ni, .tec_i(tec_o), .rec_i(rec_o), .bus_off_i(bus_off_o),
    .err_o(err_warn_o), .chg_o(stat_chg_o)
  );

  p_rec_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_off_o) |-> (rec_o == '0));
  p_exit_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_off_o) |-> (tec_o == '0) && (rec_o == '0) && !reset_mode_o);
endmodule

// File: tb/sim_can_busoff_ctrl.sv
`timescale 1ns/1ps
module sim_can_busoff_ctrl;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic mode_wr = 0, mode_val = 0, tec_wr = 0, tx_err = 0, rx_err = 0, bus_free = 0;
  logic [7:0] tec_wdata = 0, tx_amt = 0, rx_amt = 0;
  logic [7:0] tec, rec;
  logic rmode, boff, warn, evt, chg;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  can_busoff_ctrl u0 (
    .clk_i(clk), .rst_ni, .mode_wr_i(mode_wr), .mode_val_i(mode_val),
    .tec_wr_i(tec_wr), .tec_wdata_i(tec_wdata), .tx_err_i(tx_err),
    .tx_err_amt_i(tx_amt), .rx_err_i(rx_err), .rx_err_amt_i(rx_amt),
    .bus_free_i(bus_free), .tec_o(tec), .rec_o(rec), .reset_mode_o(rmode),
    .bus_off_o(boff), .err_warn_o(warn), .bus_off_evt_o(evt), .stat_chg_o(chg)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    mode_wr = 0; tec_wr = 0; tx_err = 0; rx_err = 0; bus_free = 0;
  endtask
  task automatic set_mode(bit v); mode_wr = 1; mode_val = v; step(); endtask
  task automatic wr_tec(int v); tec_wr = 1; tec_wdata = 8'(v); step(); endtask
  task automatic tx(int a); tx_err = 1; tx_amt = 8'(a); step(); endtask
  task automatic rx(int a); rx_err = 1; rx_amt = 8'(a); step(); endtask
  task automatic free(); bus_free = 1; step(); endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    int t;
    int r;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset_mode", rmode, 1);
    chk("R1 tec", tec, 0); chk("R1 rec", rec, 0);
    chk("R1 bus_off", boff, 0); chk("R1 warn", warn, 0);
    chk("R1 evt", evt, 0); chk("R1 chg", chg, 0);

    // R2/R11: errors ignored in reset mode
    tx(50); chk("R2 tx ignored in reset mode", tec, 0);
    rx(50); chk("R11 rx ignored in reset mode", rec, 0);

    // R4/R5/R6/R9 sweep of every written value
    for (int v = 0; v < 256; v++) begin
      wr_tec(v);
      chk("R4 write loads", tec, v);
      chk("R4 no bus-off in reset mode", boff, 0);
      set_mode(0);
      if (v == 255) begin
        chk("R5 bus_off", boff, 1); chk("R5 tec", tec, 127);
        chk("R5 reset_mode", rmode, 1); chk("R5 evt", evt, 1);
        chk("R10 chg on bus-off", chg, 1);
      end else begin
        chk("R6 bus_off", boff, 0); chk("R6 tec kept", tec, v);
        chk("R6 reset_mode", rmode, 0);
        chk("R9 warn", warn, (v >= 96) ? 1 : 0);
        wr_tec(3); chk("R4 write ignored outside reset mode", tec, v);
        set_mode(1);
      end
    end
    step(); chk("R5 evt one cycle", evt, 0);

    // R7/R8 recovery with interruption
    free(); chk("R8 free ignored in reset mode", tec, 127);
    set_mode(0); chk("R7 still bus_off", boff, 1); chk("R7 tec held", tec, 127);
    t = 127;
    for (int k = 0; k < 50; k++) begin
      free(); t--;
      chk("R7 step", tec, t);
      if (t == 95) chk("R10 chg on warn drop", chg, 1);
    end
    set_mode(1);
    for (int k = 0; k < 5; k++) begin
      free(); chk("R8 frozen", tec, 77); chk("R8 stays bus_off", boff, 1);
    end
    set_mode(0);
    for (int k = 0; k < 77; k++) begin
      free(); t--;
      chk("R7 step", tec, t);
      chk("R7 bus_off during recovery", boff, 1);
    end
    free();
    chk("R7 bus_off cleared", boff, 0); chk("R7 tec", tec, 0);
    chk("R7 rec", rec, 0); chk("R10 chg on recovery", chg, 1);
    step(); chk("R10 chg one cycle", chg, 0);

    // R11 receive counter with saturation, R9 from rec
    r = 0;
    for (int k = 0; k < 4; k++) begin
      rx(90); r = (r + 90 > 255) ? 255 : r + 90;
      chk("R11 rec", rec, r);
      chk("R9 warn from rec", warn, (r >= 96) ? 1 : 0);
    end

    // R2/R3 overflow through accumulated increments
    t = 0;
    for (int k = 0; k < 31; k++) begin
      tx(8); t += 8; chk("R2 tec add", tec, t);
    end
    tx(8);
    chk("R3 bus_off", boff, 1); chk("R3 tec", tec, 127);
    chk("R3 rec cleared", rec, 0); chk("R3 reset_mode", rmode, 1);
    chk("R3 evt", evt, 1);
    step(); chk("R3 evt one cycle", evt, 0);
    tx(8); chk("R2 tx ignored in bus-off", tec, 127);

    done = 1;
    finish_run();
  end
endmodule